// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 65,536 words by 16 bits. The RAM has two byte lanes: bits 7..0 form the lower lane and bits 15..8 the upper lane, and each lane has its own active-low enable. The host presents one word-sized read or write at a time. Each request carries an address, write data and a two-bit lane mask. The controller turns the request into a timed sequence of active-low chip select, output enable, write enable and lane enables. It also drives the address bus and a split data bus made of a data output, a drive enable and a data input.

All memory-side signals come straight from flip-flops. The strobe lengths are derived at elaboration from the memory access time, the write pulse width and the clock period. Writes always keep output enable high. The controller drives the data bus only from the cycle before the write strobe until one cycle after it ends. When a write follows a read, an extra idle cycle separates the RAM's output drivers from the controller's drivers.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls: chip select, output enable, write enable and both lane enables are high, the data bus is not driven, `req_ready` is high and `rsp_valid` is low.
- R2: A read with a nonzero mask holds chip select and output enable low, with write enable high, for exactly READ_WAIT cycles starting the cycle after acceptance. `rsp_valid` then pulses for one cycle, READ_WAIT+1 cycles after acceptance, carrying data sampled at the end of the strobe.
- R3: Lane enable bit 0 (lower lane, data bits 7..0) is the inverse of mask bit 0, and lane enable bit 1 (upper lane, data bits 15..8) is the inverse of mask bit 1. Read data bits of a lane whose mask bit is 0 return as zero.
- R4: A nonzero-mask write first spends one setup cycle with chip select low, write enable high and data driven. It then holds write enable low for exactly WRITE_WAIT cycles. Only lanes whose mask bit is 1 are written.
- R5: Output enable is high in every cycle in which the data bus is driven or write enable is low.
- R6: While write enable is low, address and write data stay stable. In the cycle after write enable rises, chip select is high and the data bus is still driven.
- R7: A write accepted when the most recent nonzero-mask transfer was a read gets one extra idle cycle: write enable falls in the third cycle after acceptance instead of the second. The rising edge of the drive enable is preceded by at least two cycles with output enable high.
- R8: A zero-mask write is accepted and causes no strobe and no memory change, and `req_ready` stays high. A zero-mask read is accepted and answers with `rsp_valid` and all-zero data in the next cycle, with no strobe.
- R9: `req_ready` is high only while the controller is idle. It is low from the cycle after a nonzero-mask request is accepted until the transfer ends. Chip select is high whenever `req_ready` is high.
- R10: READ_WAIT is the larger of 1 and ceil(T_ACCESS_PS / T_CLK_PS). WRITE_WAIT is the larger of 1 and ceil(T_PULSE_PS / T_CLK_PS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | LANES | Lane select, bit 0 lower lane |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | LANES | Lane enables, active low, bit 0 lower lane |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data toward memory |
| mem_dq_drive | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
The situation hardest to reach from the ports is a write that follows a read. In that case the controller must add its turnaround cycle, including when idle time separates the two. The bench reaches it by issuing a read right before each partial write in its address sweep, and by one read–idle–write sequence. It counts the cycles from acceptance to the write-enable fall in each case and compares that count with the count for back-to-back writes. The bench's memory model returns corrupted data if a read strobe has not lasted the full access time, so a shortened strobe shows up as wrong read data.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_STROBE,
      ST_WR_SETUP,
      ST_WR_STROBE,
      ST_TURN
   } asram_state_e;

   // Clock cycles covering a duration, never fewer than one.
   function automatic int unsigned wait_cycles(input int unsigned t_ps,
                                               input int unsigned clk_ps);
      int unsigned n;
      n = (t_ps + clk_ps - 1) / clk_ps;
      return (n < 1) ? 1 : n;
   endfunction

endpackage

// File: rtl/asram_wait_timer.sv
module asram_wait_timer #(
   parameter int unsigned READ_WAIT  = 2,
   parameter int unsigned WRITE_WAIT = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic sel_write,
   output logic last
);
   localparam int unsigned MAX_WAIT = (READ_WAIT > WRITE_WAIT) ? READ_WAIT : WRITE_WAIT;
   localparam int unsigned CNT_W    = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;
   localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(READ_WAIT - 1);
   localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WRITE_WAIT - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (start)
         cnt_q <= sel_write ? WR_LOAD : RD_LOAD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_lane_map.sv
module asram_lane_map #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 8
) (
   input  logic [LANES-1:0]        mask,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES-1:0]        lane_n,
   output logic [LANES*LANE_W-1:0] gated
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_n[i] = ~mask[i];
      assign gated[i*LANE_W +: LANE_W] = mask[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
   end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              tmr_start,
   output logic              tmr_sel_wr,
   input  logic              tmr_last,
   output logic [LANES-1:0]  act_mask,
   input  logic [LANES-1:0]  act_lane_n,
   input  logic [DATA_W-1:0] act_gated,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_lane_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_drive
);
   asram_state_e      state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  mask_q;
   logic              last_rd_q;
   logic              accept;
   logic              nz_mask;

   assign req_ready  = (state_q == ST_IDLE);
   assign accept     = req_ready && req_valid;
   assign nz_mask    = |req_mask;
   assign act_mask   = (state_q == ST_IDLE) ? req_mask : mask_q;
   assign tmr_start  = (accept && nz_mask && !req_write) || (state_q == ST_WR_SETUP);
   assign tmr_sel_wr = (state_q == ST_WR_SETUP);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q      <= ST_IDLE;
         addr_q       <= '0;
         wdata_q      <= '0;
         mask_q       <= '0;
         last_rd_q    <= 1'b0;
         rsp_valid    <= 1'b0;
         rsp_rdata    <= '0;
         mem_cs_n     <= 1'b1;
         mem_oe_n     <= 1'b1;
         mem_we_n     <= 1'b1;
         mem_lane_n   <= '1;
         mem_addr     <= '0;
         mem_dq_out   <= '0;
         mem_dq_drive <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               mem_dq_drive <= 1'b0;
               if (accept) begin
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  mask_q  <= req_mask;
                  if (!nz_mask) begin
                     if (!req_write) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= '0;
                     end
                  end else if (!req_write) begin
                     state_q    <= ST_RD_STROBE;
                     last_rd_q  <= 1'b1;
                     mem_cs_n   <= 1'b0;
                     mem_oe_n   <= 1'b0;
                     mem_lane_n <= act_lane_n;
                     mem_addr   <= req_addr;
                  end else if (last_rd_q) begin
                     state_q <= ST_TURN;
                  end else begin
                     state_q      <= ST_WR_SETUP;
                     mem_cs_n     <= 1'b0;
                     mem_lane_n   <= act_lane_n;
                     mem_addr     <= req_addr;
                     mem_dq_out   <= req_wdata;
                     mem_dq_drive <= 1'b1;
                  end
               end
            end
            ST_RD_STROBE: begin
               if (tmr_last) begin
                  state_q    <= ST_IDLE;
                  rsp_valid  <= 1'b1;
                  rsp_rdata  <= act_gated;
                  mem_cs_n   <= 1'b1;
                  mem_oe_n   <= 1'b1;
                  mem_lane_n <= '1;
               end
            end
            ST_TURN: begin
               state_q      <= ST_WR_SETUP;
               last_rd_q    <= 1'b0;
               mem_cs_n     <= 1'b0;
               mem_lane_n   <= act_lane_n;
               mem_addr     <= addr_q;
               mem_dq_out   <= wdata_q;
               mem_dq_drive <= 1'b1;
            end
            ST_WR_SETUP: begin
               state_q   <= ST_WR_STROBE;
               last_rd_q <= 1'b0;
               mem_we_n  <= 1'b0;
            end
            ST_WR_STROBE: begin
               if (tmr_last) begin
                  state_q    <= ST_IDLE;
                  mem_we_n   <= 1'b1;
                  mem_cs_n   <= 1'b1;
                  mem_lane_n <= '1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned LANES       = 2,
   parameter int unsigned T_CLK_PS    = 8000,
   parameter int unsigned T_ACCESS_PS = 12000,
   parameter int unsigned T_PULSE_PS  = 8000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_lane_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_drive,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int unsigned LANE_W     = DATA_W / LANES;
   localparam int unsigned READ_WAIT  = asram_pkg::wait_cycles(T_ACCESS_PS, T_CLK_PS);
   localparam int unsigned WRITE_WAIT = asram_pkg::wait_cycles(T_PULSE_PS, T_CLK_PS);

   if (LANES == 0 || (DATA_W % LANES) != 0) begin : g_bad_lanes
      $error("DATA_W must split evenly into LANES lanes");
   end
   if (ADDR_W == 0 || T_CLK_PS == 0) begin : g_bad_cfg
      $error("ADDR_W and T_CLK_PS must be nonzero");
   end

   logic              tmr_start;
   logic              tmr_sel_wr;
   logic              tmr_last;
   logic [LANES-1:0]  act_mask;
   logic [LANES-1:0]  act_lane_n;
   logic [DATA_W-1:0] act_gated;

   asram_wait_timer #(
      .READ_WAIT  (READ_WAIT),
      .WRITE_WAIT (WRITE_WAIT)
   ) u_timer (
      .clk       (clk),
      .rst       (rst),
      .start     (tmr_start),
      .sel_write (tmr_sel_wr),
      .last      (tmr_last)
   );

   asram_lane_map #(
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_lanes (
      .mask   (act_mask),
      .dq_in  (mem_dq_in),
      .lane_n (act_lane_n),
      .gated  (act_gated)
   );

   asram_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_seq (
      .clk          (clk),
      .rst          (rst),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .req_mask     (req_mask),
      .req_ready    (req_ready),
      .rsp_valid    (rsp_valid),
      .rsp_rdata    (rsp_rdata),
      .tmr_start    (tmr_start),
      .tmr_sel_wr   (tmr_sel_wr),
      .tmr_last     (tmr_last),
      .act_mask     (act_mask),
      .act_lane_n   (act_lane_n),
      .act_gated    (act_gated),
      .mem_cs_n     (mem_cs_n),
      .mem_oe_n     (mem_oe_n),
      .mem_we_n     (mem_we_n),
      .mem_lane_n   (mem_lane_n),
      .mem_addr     (mem_addr),
      .mem_dq_out   (mem_dq_out),
      .mem_dq_drive (mem_dq_drive)
   );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              req_ready,
   input logic              mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [LANES-1:0]  mem_lane_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_drive
);
   // R9: idle means chip deselected and no strobes
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n));

   // R5: never drive the bus while the memory may drive it
   p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (rst)
      mem_dq_drive |-> mem_oe_n);

   // R2: a read strobe is selected and not writing
   p_read_frame_r2: assert property (@(posedge clk) disable iff (rst)
      !mem_oe_n |-> (!mem_cs_n && mem_we_n));

   // R4: write strobe only inside a selected, driven frame with a lane on
   p_we_frame_r4: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_drive && !(&mem_lane_n)));

   // R6: address and data steady through the write pulse
   p_addr_stable_r6: assert property (@(posedge clk) disable iff (rst)
      (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

   // R6: data still driven and chip released right after the pulse
   p_release_after_we_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> (mem_dq_drive && mem_cs_n));

   // R7: two output-enable-high cycles before the controller drives
   p_turnaround_gap_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_dq_drive) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));
endmodule

bind async_sram_ctrl asram_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .LANES  (LANES)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .req_ready    (req_ready),
   .mem_cs_n     (mem_cs_n),
   .mem_oe_n     (mem_oe_n),
   .mem_we_n     (mem_we_n),
   .mem_lane_n   (mem_lane_n),
   .mem_addr     (mem_addr),
   .mem_dq_out   (mem_dq_out),
   .mem_dq_drive (mem_dq_drive)
);

// File: tb/async_sram_ctrl_test.sv
`timescale 1ns/1ps
module async_sram_ctrl_test;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam int CLK_PS = 8000;
   localparam int ACC_PS = 20000;
   localparam int PUL_PS = 10000;
   // R10: expected wait counts computed from the timing figures
   localparam int RW_EXP = ((ACC_PS + CLK_PS - 1) / CLK_PS) < 1 ? 1 : (ACC_PS + CLK_PS - 1) / CLK_PS;
   localparam int WW_EXP = ((PUL_PS + CLK_PS - 1) / CLK_PS) < 1 ? 1 : (PUL_PS + CLK_PS - 1) / CLK_PS;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0] req_mask = '0;
   logic req_ready, rsp_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_drive;
   logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
   logic [1:0] mem_lane_n;
   logic [AW-1:0] mem_addr;

   int checks = 0, fails = 0, cyc = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   async_sram_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .LANES(2),
      .T_CLK_PS(CLK_PS), .T_ACCESS_PS(ACC_PS), .T_PULSE_PS(PUL_PS)
   ) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_lane_n(mem_lane_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
      .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [DW-1:0] mem [16];
   int acc = 0;
   always_comb begin
      mem_dq_in = 16'h0000;
      for (int i = 0; i < 2; i++) begin
         if (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_lane_n[i])
            mem_dq_in[i*8 +: 8] = (acc >= RW_EXP) ? mem[mem_addr][i*8 +: 8] : ~mem[mem_addr][i*8 +: 8];
         else
            mem_dq_in[i*8 +: 8] = 8'hA5;
      end
   end

   logic p_we = 1'b1, p_oe = 1'b1;
   logic [AW-1:0] p_addr = '0;
   logic [DW-1:0] p_dq = '0;
   int oe_run = 0, we_run = 0;

   always @(negedge clk) begin
      if (rst) begin
         acc <= 0; oe_run = 0; we_run = 0; p_we = 1'b1; p_oe = 1'b1;
      end else begin
         acc <= (!mem_cs_n && !mem_oe_n && mem_we_n) ? acc + 1 : 0;
         if (!mem_cs_n && !mem_we_n) begin
            for (int i = 0; i < 2; i++)
               if (!mem_lane_n[i]) mem[mem_addr][i*8 +: 8] <= mem_dq_out[i*8 +: 8];
         end
         // R5: output enable high while driving or writing
         if (mem_dq_drive || !mem_we_n)
            check(mem_oe_n, "R5 oe_n during write", {31'd0, mem_oe_n}, 32'd1);
         // R6: stability during pulse
         if (!mem_we_n && !p_we)
            check(mem_addr == p_addr && mem_dq_out == p_dq, "R6 addr/data stable",
                  {mem_addr, mem_dq_out}, {p_addr, p_dq});
         if (mem_we_n && !p_we)
            check(mem_dq_drive && mem_cs_n, "R6 release after we", {mem_dq_drive, mem_cs_n}, 2'b11);
         // R2/R10 and R4/R10: strobe lengths
         if (!mem_oe_n) oe_run++;
         else if (!p_oe) begin
            check(oe_run == RW_EXP, "R2 R10 read strobe length", oe_run, RW_EXP);
            oe_run = 0;
         end
         if (!mem_we_n) we_run++;
         else if (!p_we) begin
            check(we_run == WW_EXP, "R4 R10 write strobe length", we_run, WW_EXP);
            we_run = 0;
         end
         p_we = mem_we_n; p_oe = mem_oe_n; p_addr = mem_addr; p_dq = mem_dq_out;
      end
   end

   // ---------------- host tasks ----------------
   logic [DW-1:0] got;

   task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [1:0] m, output int lat);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      if (m == 2'b00 && w) return;
      if (!w) begin
         while (!rsp_valid && lat < 200) begin @(negedge clk); lat++; end
         got = rsp_rdata;
      end else begin
         while (mem_we_n && lat < 200) begin @(negedge clk); lat++; end
         while (!req_ready) @(negedge clk);
      end
   endtask

   function automatic logic [DW-1:0] pat_f(input int a);
      return 16'((a * 16'h1357) ^ 16'hC3A1);
   endfunction
   function automatic logic [DW-1:0] pat_g(input int a);
      return 16'((a * 16'h0101) ^ 16'h5A5A);
   endfunction
   function automatic logic [DW-1:0] lane_mask(input logic [1:0] m);
      return {{8{m[1]}}, {8{m[0]}}};
   endfunction

   logic [DW-1:0] shadow [16];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected<100000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int lat;
      for (int i = 0; i < 16; i++) mem[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      // R1: reset state
      check({mem_cs_n, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_drive, req_ready, rsp_valid} == 8'b1111_1010,
            "R1 reset outputs", {mem_cs_n, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_drive, req_ready, rsp_valid},
            8'b1111_1010);
      rst = 1'b0;
      @(negedge clk);
      check(req_ready && mem_cs_n && !mem_dq_drive && !rsp_valid, "R1 after reset",
            {req_ready, mem_cs_n, mem_dq_drive, rsp_valid}, 4'b1100);

      // R4 R7: full writes back to back, no turnaround
      for (int a = 0; a < 16; a++) begin
         xfer(1'b1, AW'(a), pat_f(a), 2'b11, lat);
         shadow[a] = pat_f(a);
         check(lat == 2, "R7 R4 write latency after write", lat, 2);
      end

      // R2 R3: read each address with each nonzero mask
      for (int a = 0; a < 16; a++) begin
         for (int m = 1; m < 4; m++) begin
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a); req_mask = 2'(m);
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            check(!req_ready, "R9 ready low during read", {31'd0, req_ready}, 0);
            check(mem_lane_n == ~2'(m), "R3 lane enables", mem_lane_n, ~2'(m));
            lat = 1;
            while (!rsp_valid && lat < 200) begin @(negedge clk); lat++; end
            check(lat == RW_EXP + 1, "R2 read latency", lat, RW_EXP + 1);
            check(rsp_rdata == (shadow[a] & lane_mask(2'(m))), "R3 R2 read data",
                  rsp_rdata, shadow[a] & lane_mask(2'(m)));
            check(req_ready, "R9 ready after read", {31'd0, req_ready}, 1);
            @(negedge clk);
            check(!rsp_valid, "R2 rsp_valid single pulse", {31'd0, rsp_valid}, 0);
         end
      end

      // R7 R4: read then partial writes, read back merged
      for (int a = 0; a < 16; a++) begin
         xfer(1'b0, AW'(a), '0, 2'b11, lat);
         if (a == 7) repeat (4) @(negedge clk);
         xfer(1'b1, AW'(a), pat_g(a), 2'b01, lat);
         check(lat == 3, "R7 turnaround after read", lat, 3);
         xfer(1'b1, AW'(a), ~pat_g(a), 2'b10, lat);
         check(lat == 2, "R7 no turnaround after write", lat, 2);
         shadow[a] = {~pat_g(a)} & 16'hFF00 | pat_g(a) & 16'h00FF;
         xfer(1'b0, AW'(a), '0, 2'b11, lat);
         check(got == shadow[a], "R4 partial lane write", got, shadow[a]);
      end

      // R8: zero-mask write leaves memory and strobes alone
      xfer(1'b1, 4'd5, 16'h0F0F, 2'b00, lat);
      for (int k = 0; k < 3; k++) begin
         check(mem_cs_n && mem_we_n && req_ready, "R8 zero-mask write idle",
               {mem_cs_n, mem_we_n, req_ready}, 3'b111);
         @(negedge clk);
      end
      xfer(1'b0, 4'd5, '0, 2'b11, lat);
      check(got == shadow[5], "R8 zero-mask write no change", got, shadow[5]);
      // R8: zero-mask read answers next cycle with zero
      xfer(1'b0, 4'd9, '0, 2'b00, lat);
      check(lat == 1 && got == 16'h0000, "R8 zero-mask read", {lat[15:0], got}, 32'h0001_0000);
      check(mem_cs_n, "R8 zero-mask read no strobe", {31'd0, mem_cs_n}, 1);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule